// File: doc/BRIEF.md
# Tape Command Mailbox and Interrupt Sequencer

This block sits on the controller side of a tape subsystem, between a host register interface and the engine that moves the tape. The host first checks the busy flag in the top bit of a 16-bit interrupt-vector register. It then loads a parameter register that picks the drive unit and the track. Last, it writes a non-zero opcode into the command register. A zero in the command register means there is nothing to do, and the sequencer waits.

Once a command is taken in, the sequencer clears the interrupt-pending flag, raises busy and checks the opcode. A legal opcode drives the active-low unit-select and track-select lines and sends a one-cycle start pulse to the execution engine, then waits for the engine's done/error reply. An illegal opcode skips the engine and is reported as an error. After completion the command register returns to zero, busy drops, the error code is placed in the vector's upper byte, interrupt-pending is set and an interrupt request is raised. When the host acknowledges, the sequencer puts the full vector on the data bus for one cycle and sets interrupt-under-service. The host clears interrupt-under-service later with a separate write.

Top module: `tape_cmd_sequencer`

## Requirements
- R1: After reset: command register 0, busy 0, error 0, interrupt-pending 0, interrupt-under-service 0, int_req 0, data_oe 0, eng_start 0, sel_n = 3'b111 and trk_n = 2'b11.
- R2: While the command register (host address 0) holds zero the block stays idle. One clock edge after a non-zero value is written, busy is 1 and interrupt-pending is 0.
- R3: Opcodes 1..MAX_OP are legal. The edge after busy rises, a legal opcode gives a single-cycle eng_start with eng_op equal to the opcode. An illegal opcode (above MAX_OP) never produces eng_start.
- R4: During execution sel_n = {SL4,SL2,SL1} encodes the unit in parameter bits [1:0]: unit 0 = 3'b110, 1 = 3'b101, 2 = 3'b100, 3 = 3'b011. At all other times sel_n = 3'b111.
- R5: During execution trk_n = {TR2,TR1} encodes the track in parameter bits [3:2]: track 0 = 2'b10, 1 = 2'b01, 2 = 2'b00, 3 = 2'b11. At all other times trk_n = 2'b11.
- R6: On completion the command register returns to 0, busy returns to 0, interrupt-pending goes to 1, and int_req stays high until int_ack.
- R7: A clock edge that samples int_ack while int_req is high sets interrupt-under-service, drops int_req, and for the next cycle drives data_oe = 1 with data_bus equal to the vector.
- R8: Vector layout: bit 15 is busy, bits 14:8 are the error code, and bits 7:0 are the host-written low byte (host address 3). The error code is 0x00 on success, 0x01 for an illegal opcode and 0x02 when the engine reports an error.
- R9: Writes to the command register or the parameter register are ignored while busy is 1.
- R10: A host write to address 2 with data bit 0 set clears interrupt-under-service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register select: 0 command, 1 parameter, 2 interrupt control, 3 vector low byte |
| host_wdata | input | 16 | Host write data |
| cmd_q | output | CMD_W | Command register readback |
| vec_q | output | 16 | Interrupt-vector register readback |
| irq_pend | output | 1 | Interrupt-pending flag |
| irq_svc | output | 1 | Interrupt-under-service flag |
| int_req | output | 1 | Interrupt request to the host |
| int_ack | input | 1 | Interrupt acknowledge from the host |
| data_bus | output | 16 | Vector presented after acknowledge |
| data_oe | output | 1 | Qualifies data_bus |
| eng_start | output | 1 | One-cycle start pulse to the execution engine |
| eng_op | output | CMD_W | Opcode passed with the start pulse |
| eng_done | input | 1 | Engine completion strobe |
| eng_err | input | 1 | Engine failure flag, sampled with eng_done |
| sel_n | output | 3 | Active-low drive-select lines {SL4,SL2,SL1} |
| trk_n | output | 2 | Active-low track-select lines {TR2,TR1} |

## Verification
Assertions check the rules that hold on every cycle. These are: acceptance of a non-zero command raises busy and clears interrupt-pending; an illegal opcode never starts the engine; the start pulse lasts one cycle; completion clears the command and raises the request; an acknowledge yields the vector and interrupt-under-service; select lines stay released outside execution; and writes have no effect while busy. Some behaviour can only be shown by the bench's scenarios. That covers the exact select and track codes for each unit and track, the error-code values seen on the bus for success, an illegal opcode and an engine failure, a command written during execution never running afterwards, and the host-driven clearing of interrupt-under-service.

// File: rtl/tape_mbx_pkg.sv
package tape_mbx_pkg;

    localparam int VEC_W = 16;
    localparam int LOW_W = VEC_W / 2;
    localparam int ERR_W = VEC_W - LOW_W - 1;

    localparam logic [ERR_W-1:0] ERR_NONE   = ERR_W'(0);
    localparam logic [ERR_W-1:0] ERR_BADOP  = ERR_W'(1);
    localparam logic [ERR_W-1:0] ERR_ENGINE = ERR_W'(2);

    localparam logic [2:0] SEL_IDLE = 3'b111;
    localparam logic [1:0] TRK_IDLE = 2'b11;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_EXEC,
        S_DONE,
        S_IRQ
    } seq_state_e;

    typedef enum logic [1:0] {
        A_CMD  = 2'd0,
        A_PARM = 2'd1,
        A_ICTL = 2'd2,
        A_VLOW = 2'd3
    } host_addr_e;

    typedef struct packed {
        logic [1:0] track;
        logic [1:0] unit;
    } tape_parm_t;

    typedef struct packed {
        logic             busy;
        logic [ERR_W-1:0] err;
        logic [LOW_W-1:0] low;
    } int_vec_t;

    function automatic logic [2:0] unit_to_sel_n(input logic [1:0] unit);
        case (unit)
            2'd0:    return 3'b110;
            2'd1:    return 3'b101;
            2'd2:    return 3'b100;
            default: return 3'b011;
        endcase
    endfunction

    function automatic logic [1:0] track_to_trk_n(input logic [1:0] track);
        case (track)
            2'd0:    return 2'b10;
            2'd1:    return 2'b01;
            2'd2:    return 2'b00;
            default: return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/tape_host_regs.sv
module tape_host_regs
    import tape_mbx_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [VEC_W-1:0] wdata,
    input  logic             busy,
    input  logic             cmd_clr,
    output logic [CMD_W-1:0] cmd_q,
    output tape_parm_t       parm_q,
    output logic [LOW_W-1:0] vlow_q,
    output logic             ius_clr
);

    logic wr_cmd, wr_parm, wr_vlow;

    always_comb begin
        wr_cmd  = we && (addr == A_CMD);
        wr_parm = we && (addr == A_PARM);
        wr_vlow = we && (addr == A_VLOW);
        ius_clr = we && (addr == A_ICTL) && wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            parm_q <= '0;
            vlow_q <= '0;
        end else begin
            if (cmd_clr)
                cmd_q <= '0;
            else if (wr_cmd && !busy)
                cmd_q <= wdata[CMD_W-1:0];
            if (wr_parm && !busy)
                parm_q <= tape_parm_t'(wdata[3:0]);
            if (wr_vlow)
                vlow_q <= wdata[LOW_W-1:0];
        end
    end

    a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        busy && !cmd_clr |=> $stable(cmd_q) && $stable(parm_q));

    a_r6_cmd_returns_zero: assert property (@(posedge clk) disable iff (rst)
        cmd_clr |=> cmd_q == '0);

endmodule

// File: rtl/tape_sel_drive.sv
module tape_sel_drive
    import tape_mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       release_sel,
    input  tape_parm_t parm,
    output logic [2:0] sel_n,
    output logic [1:0] trk_n
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_n <= SEL_IDLE;
            trk_n <= TRK_IDLE;
        end else if (load) begin
            sel_n <= unit_to_sel_n(parm.unit);
            trk_n <= track_to_trk_n(parm.track);
        end else if (release_sel) begin
            sel_n <= SEL_IDLE;
            trk_n <= TRK_IDLE;
        end
    end

    a_r4_one_or_two_low: assert property (@(posedge clk) disable iff (rst)
        $countones(~sel_n) <= 2);

endmodule

// File: rtl/tape_seq_fsm.sv
module tape_seq_fsm
    import tape_mbx_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int MAX_OP = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMD_W-1:0] cmd_q,
    input  logic [LOW_W-1:0] vlow,
    input  logic             ius_clr,
    input  logic             int_ack,
    input  logic             eng_done,
    input  logic             eng_err,
    output seq_state_e       state,
    output logic             busy,
    output logic [ERR_W-1:0] err,
    output logic             ip,
    output logic             ius,
    output logic             int_req,
    output logic             eng_start,
    output logic [CMD_W-1:0] eng_op,
    output logic             cmd_clr,
    output logic             sel_load,
    output logic             sel_release,
    output logic [VEC_W-1:0] data_bus,
    output logic             data_oe
);

    localparam logic [CMD_W-1:0] OP_MAX = CMD_W'(MAX_OP);

    logic     op_ok;
    int_vec_t vec_now;

    always_comb begin
        op_ok       = (cmd_q != '0) && (cmd_q <= OP_MAX);
        int_req     = (state == S_IRQ);
        cmd_clr     = (state == S_DONE);
        sel_load    = (state == S_CHECK) && op_ok;
        sel_release = (state == S_EXEC) && eng_done;
        vec_now     = '{busy: busy, err: err, low: vlow};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            busy      <= 1'b0;
            err       <= ERR_NONE;
            ip        <= 1'b0;
            ius       <= 1'b0;
            eng_start <= 1'b0;
            eng_op    <= '0;
            data_bus  <= '0;
            data_oe   <= 1'b0;
        end else begin
            eng_start <= 1'b0;
            data_oe   <= 1'b0;
            data_bus  <= '0;
            if (int_req && int_ack)
                ius <= 1'b1;
            else if (ius_clr)
                ius <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (cmd_q != '0) begin
                        state <= S_CHECK;
                        busy  <= 1'b1;
                        ip    <= 1'b0;
                        err   <= ERR_NONE;
                    end
                end
                S_CHECK: begin
                    if (op_ok) begin
                        state     <= S_EXEC;
                        eng_start <= 1'b1;
                        eng_op    <= cmd_q;
                    end else begin
                        state <= S_DONE;
                        err   <= ERR_BADOP;
                    end
                end
                S_EXEC: begin
                    if (eng_done) begin
                        state <= S_DONE;
                        err   <= eng_err ? ERR_ENGINE : ERR_NONE;
                    end
                end
                S_DONE: begin
                    state <= S_IRQ;
                    ip    <= 1'b1;
                    busy  <= 1'b0;
                end
                S_IRQ: begin
                    if (int_ack) begin
                        state    <= S_IDLE;
                        data_oe  <= 1'b1;
                        data_bus <= vec_now;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    a_r2_accept_marks_busy: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) && (cmd_q != '0) |=> busy && !ip);

    a_r3_bad_op_no_start: assert property (@(posedge clk) disable iff (rst)
        (state == S_CHECK) && !op_ok |=> !eng_start && (err == ERR_BADOP));

    a_r3_start_single_cycle: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    a_r6_completion_flags: assert property (@(posedge clk) disable iff (rst)
        (state == S_DONE) |=> ip && !busy && int_req);

    a_r7_ack_presents_vector: assert property (@(posedge clk) disable iff (rst)
        int_req && int_ack |=> data_oe && ius && !int_req && !data_bus[VEC_W-1]);

endmodule

// File: rtl/tape_cmd_sequencer.sv
module tape_cmd_sequencer
    import tape_mbx_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int MAX_OP = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_we,
    input  logic [1:0]       host_addr,
    input  logic [15:0]      host_wdata,
    output logic [CMD_W-1:0] cmd_q,
    output logic [15:0]      vec_q,
    output logic             irq_pend,
    output logic             irq_svc,
    output logic             int_req,
    input  logic             int_ack,
    output logic [15:0]      data_bus,
    output logic             data_oe,
    output logic             eng_start,
    output logic [CMD_W-1:0] eng_op,
    input  logic             eng_done,
    input  logic             eng_err,
    output logic [2:0]       sel_n,
    output logic [1:0]       trk_n
);

    seq_state_e       state;
    logic             busy, cmd_clr, ius_clr, sel_load, sel_release;
    logic [ERR_W-1:0] err;
    logic [LOW_W-1:0] vlow;
    tape_parm_t       parm;
    int_vec_t         vec_s;

    tape_host_regs #(.CMD_W(CMD_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (host_we),
        .addr    (host_addr),
        .wdata   (host_wdata),
        .busy    (busy),
        .cmd_clr (cmd_clr),
        .cmd_q   (cmd_q),
        .parm_q  (parm),
        .vlow_q  (vlow),
        .ius_clr (ius_clr)
    );

    tape_seq_fsm #(.CMD_W(CMD_W), .MAX_OP(MAX_OP)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmd_q       (cmd_q),
        .vlow        (vlow),
        .ius_clr     (ius_clr),
        .int_ack     (int_ack),
        .eng_done    (eng_done),
        .eng_err     (eng_err),
        .state       (state),
        .busy        (busy),
        .err         (err),
        .ip          (irq_pend),
        .ius         (irq_svc),
        .int_req     (int_req),
        .eng_start   (eng_start),
        .eng_op      (eng_op),
        .cmd_clr     (cmd_clr),
        .sel_load    (sel_load),
        .sel_release (sel_release),
        .data_bus    (data_bus),
        .data_oe     (data_oe)
    );

    tape_sel_drive u_sel (
        .clk         (clk),
        .rst         (rst),
        .load        (sel_load),
        .release_sel (sel_release),
        .parm        (parm),
        .sel_n       (sel_n),
        .trk_n       (trk_n)
    );

    always_comb begin
        vec_s = '{busy: busy, err: err, low: vlow};
        vec_q = vec_s;
    end

    a_r4_r5_released_outside_exec: assert property (@(posedge clk) disable iff (rst)
        (state != S_EXEC) |-> (sel_n == SEL_IDLE) && (trk_n == TRK_IDLE));

    a_r10_ius_clear_write: assert property (@(posedge clk) disable iff (rst)
        ius_clr && !int_req |=> !irq_svc);

endmodule

// File: tb/tb_tape_cmd_sequencer.sv
module tb_tape_cmd_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = 16'd0;
    logic [7:0]  cmd_q;
    logic [15:0] vec_q;
    logic        irq_pend, irq_svc, int_req, data_oe, eng_start;
    logic        int_ack = 1'b0;
    logic [15:0] data_bus;
    logic [7:0]  eng_op;
    logic        eng_done = 1'b0;
    logic        eng_err = 1'b0;
    logic [2:0]  sel_n;
    logic [1:0]  trk_n;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    tape_cmd_sequencer #(.CMD_W(8), .MAX_OP(6)) dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .cmd_q(cmd_q), .vec_q(vec_q),
        .irq_pend(irq_pend), .irq_svc(irq_svc), .int_req(int_req),
        .int_ack(int_ack), .data_bus(data_bus), .data_oe(data_oe),
        .eng_start(eng_start), .eng_op(eng_op), .eng_done(eng_done),
        .eng_err(eng_err), .sel_n(sel_n), .trk_n(trk_n)
    );

    // {valid, op[7:0], unit[1:0], track[1:0], engine_err, exp_err[6:0], exp_sel[2:0], exp_trk[1:0]}
    localparam int NV = 6;
    localparam logic [25:0] VECS [NV] = '{
        {1'b1, 8'd1,   2'd0, 2'd0, 1'b0, 7'h00, 3'b110, 2'b10},
        {1'b1, 8'd2,   2'd1, 2'd1, 1'b0, 7'h00, 3'b101, 2'b01},
        {1'b1, 8'd6,   2'd2, 2'd2, 1'b0, 7'h00, 3'b100, 2'b00},
        {1'b1, 8'd4,   2'd3, 2'd3, 1'b1, 7'h02, 3'b011, 2'b11},
        {1'b0, 8'd7,   2'd1, 2'd2, 1'b0, 7'h01, 3'b111, 2'b11},
        {1'b0, 8'hFF,  2'd0, 2'd0, 1'b0, 7'h01, 3'b111, 2'b11}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_req();
        for (int i = 0; i < 20 && !int_req; i++) @(negedge clk);
    endtask

    task automatic run_entry(input logic [25:0] v, input bit busy_write);
        logic       valid  = v[25];
        logic [7:0] op     = v[24:17];
        logic [1:0] unit   = v[16:15];
        logic [1:0] track  = v[14:13];
        logic       e_err  = v[12];
        logic [6:0] x_err  = v[11:5];
        logic [2:0] x_sel  = v[4:2];
        logic [1:0] x_trk  = v[1:0];
        host_write(2'd1, {12'd0, track, unit});
        host_write(2'd0, {8'd0, op});
        check(cmd_q == op, "R2", "cmd readback", cmd_q, op);
        @(negedge clk);
        check(vec_q[15] == 1'b1, "R2", "busy after accept", vec_q[15], 1);
        check(irq_pend == 1'b0, "R2", "IP cleared on accept", irq_pend, 0);
        @(negedge clk);
        if (valid) begin
            check(eng_start && eng_op == op, "R3", "start pulse with opcode", {eng_start, eng_op}, {1'b1, op});
            check(sel_n == x_sel, "R4", "drive select code", sel_n, x_sel);
            check(trk_n == x_trk, "R5", "track select code", trk_n, x_trk);
            if (busy_write) begin
                host_write(2'd0, 16'h0003);
                check(cmd_q == op, "R9", "command write ignored while busy", cmd_q, op);
                host_write(2'd1, 16'h0000);
            end else begin
                @(negedge clk);
                check(eng_start == 1'b0, "R3", "start lasts one cycle", eng_start, 0);
            end
            eng_done = 1'b1; eng_err = e_err;
            @(negedge clk);
            eng_done = 1'b0; eng_err = 1'b0;
        end else begin
            check(eng_start == 1'b0, "R3", "no start for illegal opcode", eng_start, 0);
        end
        wait_req();
        check(int_req == 1'b1, "R6", "interrupt request raised", int_req, 1);
        check(cmd_q == 8'd0 && irq_pend && !vec_q[15], "R6", "cmd zero, IP set, busy clear",
              {cmd_q, irq_pend, vec_q[15]}, {8'd0, 1'b1, 1'b0});
        check(sel_n == 3'b111 && trk_n == 2'b11, "R4", "lines released after run", {sel_n, trk_n}, 5'b11111);
        @(negedge clk);
        check(int_req == 1'b1, "R6", "request held until ack", int_req, 1);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
        check(data_oe == 1'b1, "R7", "vector driven", data_oe, 1);
        check(data_bus == {1'b0, x_err, 8'h5A}, "R8", "vector value", data_bus, {1'b0, x_err, 8'h5A});
        check(irq_svc == 1'b1 && int_req == 1'b0, "R7", "IUS set, request dropped", {irq_svc, int_req}, 2'b10);
        @(negedge clk);
        check(data_oe == 1'b0, "R7", "vector for one cycle only", data_oe, 0);
        host_write(2'd2, 16'h0001);
        check(irq_svc == 1'b0, "R10", "IUS cleared by host", irq_svc, 0);
        if (busy_write) begin
            repeat (4) @(negedge clk);
            check(vec_q[15] == 1'b0 && !eng_start, "R9", "ignored command never runs", vec_q[15], 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(cmd_q == 0 && vec_q == 0, "R1", "cmd and vector after reset", {cmd_q, vec_q}, 0);
        check(!irq_pend && !irq_svc && !int_req && !data_oe && !eng_start, "R1", "flags after reset",
              {irq_pend, irq_svc, int_req, data_oe, eng_start}, 0);
        check(sel_n == 3'b111 && trk_n == 2'b11, "R1", "select lines after reset", {sel_n, trk_n}, 5'b11111);

        host_write(2'd3, 16'h005A);
        check(vec_q == 16'h005A, "R8", "low byte readback", vec_q, 16'h005A);

        host_write(2'd0, 16'h0000);
        repeat (3) @(negedge clk);
        check(vec_q[15] == 1'b0 && !eng_start, "R2", "zero command stays idle", vec_q[15], 0);

        for (int i = 0; i < NV; i++) run_entry(VECS[i], 1'b0);

        run_entry(VECS[1], 1'b1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule